// File: doc/BRIEF.md
# Polynomial Noise Tone Channel

This block is a single sound voice. A slow tick enable, around 30 kHz, drives a programmable frequency divider. Each time the divider wraps it issues one step to a waveform engine. The engine holds three shift-register noise sources (4, 5 and 9 bits) and one shared phase counter that serves as a fixed square-wave divider. A 4-bit control code picks how these parts are chained, and so sets the waveform bit. The output sample is the volume value while the waveform bit is 1, and zero otherwise. Conversion to an analog level and mixing with other voices happen outside the block.

Software programs the voice through a single write strobe with a 2-bit address: 0 selects frequency, 1 selects control, 2 selects volume, and 3 selects nothing. The control code is decoded into three things:
- a waveform source: `SRC_HIGH`, `SRC_POLY4`, `SRC_POLY5`, `SRC_POLY9` or `SRC_DIV`;
- an advance gate for the 4-bit register: `ADV_HOLD`, `ADV_ALWAYS`, `ADV_POLY5` or `ADV_WRAP`;
- an advance gate and modulus for the phase counter.

The phase counter has two transitions on an advancing step: increment, or wrap to 0 when it is at or above modulus-1. The divider also has two transitions on a tick: count up, or wrap to 0 and reload its limit.

Top module: `poly_tone_channel`

## Requirements
- R1: The divider issues one step on every tick where its count is at or above its limit, and the limit then reloads from the 5-bit frequency value N. With a steady N this gives one step per N+1 ticks: 0 gives every tick and 31 gives every 32nd tick. Without a tick, nothing in the engine moves.
- R2: A new frequency value first takes effect at the next divider wrap, so the period already running finishes at its old length.
- R3: Control codes 0 and 11 hold the waveform bit at 1, so the sample equals the volume.
- R4: On every step the 5-bit and 9-bit registers advance, each shifting toward bit 0. The new top bit is bit0 XOR bit2 for the 5-bit register (x^5+x^3+1) and bit0 XOR bit4 for the 9-bit register (x^9+x^5+1). The 4-bit register uses bit0 XOR bit1 (x^4+x^3+1) and advances only when its gate allows. All three reset to all ones. Code 1 advances the 4-bit register on every step and outputs its bit 0, code 9 outputs bit 0 of the 5-bit register, and code 8 outputs bit 0 of the 9-bit register.
- R5: Code 2 runs the phase counter with modulus 15 on every step. The 4-bit register advances only on a step where the phase counter wraps, and the waveform bit is its bit 0.
- R6: Code 3 advances the 4-bit register only on steps where bit 0 of the 5-bit register (before that step) is 1, and outputs its bit 0.
- R7: Plain divider codes advance the phase counter on every step with modulus D. Codes 4 and 5 use D=2, codes 6 and 10 use D=31, codes 12 and 13 use D=6, and code 14 uses D=93. The waveform bit is 1 while phase < floor(D/2). The counter wraps to 0 when it is at or above D-1, so a leftover phase from an earlier code is brought back into range. Non-divider codes hold the phase.
- R8: Codes 7 (D=2) and 15 (D=6) advance the phase counter only on steps where bit 0 of the 5-bit register is 1.
- R9: The sample is the 4-bit volume when the waveform bit is 1 and 0 otherwise, so volume 0 is silent.
- R10: A write with address 0 loads the 5 data bits into frequency. Address 1 loads data bits 3:0 into control, and address 2 loads data bits 3:0 into volume. Address 3 changes nothing.
- R11: After reset, frequency, control, volume, the phase count and the divider are all 0, and the sample is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Base rate enable, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 frequency, 1 control, 2 volume, 3 none |
| wr_data | input | 5 | Write data |
| sample | output | 4 | Amplitude sample |

## Verification
The bench builds the block with its default 5-bit frequency and 4-bit volume widths, so the full divide range from 1 to 32 can be reached. The bench drives tick on every cycle or on every few cycles. At that rate the 93-step divider, the 511-state 9-bit sequence and the poly-gated chains all run through many full periods in a short run. A behavioural model compares the sample every cycle while all sixteen codes are exercised. The run also includes a frequency rewrite in the middle of a period, leftover phases carried across code changes, silent volume, and ignored writes to address 3.

// File: rtl/ptone_pkg.sv
package ptone_pkg;
    localparam int CODE_W = 4;
    localparam int PH_W   = 7;

    typedef enum logic [2:0] {
        SRC_HIGH,
        SRC_POLY4,
        SRC_POLY5,
        SRC_POLY9,
        SRC_DIV
    } src_e;

    typedef enum logic [1:0] {
        ADV_HOLD,
        ADV_ALWAYS,
        ADV_POLY5,
        ADV_WRAP
    } adv_e;

    typedef enum logic [1:0] {
        ADDR_FREQ = 2'd0,
        ADDR_CTRL = 2'd1,
        ADDR_VOL  = 2'd2,
        ADDR_NONE = 2'd3
    } addr_e;
endpackage

// File: rtl/tone_divider.sv
module tone_divider #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] freq,
    output logic         step
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] lim_q;
    logic         at_wrap;

    assign at_wrap = (cnt_q >= lim_q);
    assign step    = tick && at_wrap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (tick) begin
            if (at_wrap) begin
                cnt_q <= '0;
                lim_q <= freq;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assert_cnt_within_lim_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_q);
    assert_hold_without_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));
    assert_limit_only_at_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(lim_q));
endmodule

// File: rtl/tone_lfsr.sv
module tone_lfsr #(
    parameter int WIDTH = 5,
    parameter int TAP   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic out_bit
);
    logic [WIDTH-1:0] state_q;
    logic             fb;

    assign fb      = state_q[0] ^ state_q[TAP];
    assign out_bit = state_q[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '1;
        end else if (adv) begin
            state_q <= {fb, state_q[WIDTH-1:1]};
        end
    end

    assert_state_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
    assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(state_q));
endmodule

// File: rtl/tone_shaper.sv
module tone_shaper
    import ptone_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [CODE_W-1:0] code,
    input  logic              p4_bit,
    input  logic              p5_bit,
    input  logic              p9_bit,
    output logic              p4_adv,
    output logic              wave
);
    localparam logic [PH_W-1:0] PH_MAX = PH_W'(92);

    src_e            src;
    adv_e            p4_gate;
    adv_e            ph_gate;
    logic [PH_W-1:0] modulus;
    logic [PH_W-1:0] ph_q;
    logic            ph_go;
    logic            ph_wrap;

    // Mode decode
    always_comb begin
        src     = SRC_HIGH;
        p4_gate = ADV_HOLD;
        ph_gate = ADV_HOLD;
        modulus = PH_W'(1);
        unique case (code)
            4'd0, 4'd11: src = SRC_HIGH;
            4'd1: begin
                src     = SRC_POLY4;
                p4_gate = ADV_ALWAYS;
            end
            4'd2: begin
                src     = SRC_POLY4;
                p4_gate = ADV_WRAP;
                ph_gate = ADV_ALWAYS;
                modulus = PH_W'(15);
            end
            4'd3: begin
                src     = SRC_POLY4;
                p4_gate = ADV_POLY5;
            end
            4'd4, 4'd5: begin
                src     = SRC_DIV;
                ph_gate = ADV_ALWAYS;
                modulus = PH_W'(2);
            end
            4'd6, 4'd10: begin
                src     = SRC_DIV;
                ph_gate = ADV_ALWAYS;
                modulus = PH_W'(31);
            end
            4'd7: begin
                src     = SRC_DIV;
                ph_gate = ADV_POLY5;
                modulus = PH_W'(2);
            end
            4'd8: src = SRC_POLY9;
            4'd9: src = SRC_POLY5;
            4'd12, 4'd13: begin
                src     = SRC_DIV;
                ph_gate = ADV_ALWAYS;
                modulus = PH_W'(6);
            end
            4'd14: begin
                src     = SRC_DIV;
                ph_gate = ADV_ALWAYS;
                modulus = PH_W'(93);
            end
            4'd15: begin
                src     = SRC_DIV;
                ph_gate = ADV_POLY5;
                modulus = PH_W'(6);
            end
            default: src = SRC_HIGH;
        endcase
    end

    // Phase advance and wrap
    always_comb begin
        unique case (ph_gate)
            ADV_ALWAYS: ph_go = step;
            ADV_POLY5:  ph_go = step && p5_bit;
            default:    ph_go = 1'b0;
        endcase
        ph_wrap = ph_go && (ph_q >= modulus - PH_W'(1));
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (ph_go) begin
            ph_q <= ph_wrap ? '0 : ph_q + PH_W'(1);
        end
    end

    // Outputs
    always_comb begin
        unique case (p4_gate)
            ADV_ALWAYS: p4_adv = step;
            ADV_POLY5:  p4_adv = step && p5_bit;
            ADV_WRAP:   p4_adv = ph_wrap;
            default:    p4_adv = 1'b0;
        endcase
        unique case (src)
            SRC_POLY4: wave = p4_bit;
            SRC_POLY5: wave = p5_bit;
            SRC_POLY9: wave = p9_bit;
            SRC_DIV:   wave = (ph_q < (modulus >> 1));
            default:   wave = 1'b1;
        endcase
    end

    assert_phase_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q <= PH_MAX);
    assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(ph_q));
endmodule

// File: rtl/poly_tone_channel.sv
module poly_tone_channel
    import ptone_pkg::*;
#(
    parameter int FREQ_W = 5,
    parameter int VOL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [FREQ_W-1:0] wr_data,
    output logic [VOL_W-1:0]  sample
);
    logic [FREQ_W-1:0] freq_q;
    logic [CODE_W-1:0] ctrl_q;
    logic [VOL_W-1:0]  vol_q;
    logic              step;
    logic              p4_adv;
    logic              p4_bit;
    logic              p5_bit;
    logic              p9_bit;
    logic              wave;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_q <= '0;
            ctrl_q <= '0;
            vol_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_FREQ: freq_q <= wr_data;
                ADDR_CTRL: ctrl_q <= wr_data[CODE_W-1:0];
                ADDR_VOL:  vol_q  <= wr_data[VOL_W-1:0];
                default:   ;
            endcase
        end
    end

    tone_divider #(.W(FREQ_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .freq (freq_q),
        .step (step)
    );

    tone_lfsr #(.WIDTH(4), .TAP(1)) u_poly4 (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (p4_adv),
        .out_bit(p4_bit)
    );

    tone_lfsr #(.WIDTH(5), .TAP(2)) u_poly5 (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (step),
        .out_bit(p5_bit)
    );

    tone_lfsr #(.WIDTH(9), .TAP(4)) u_poly9 (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (step),
        .out_bit(p9_bit)
    );

    tone_shaper u_shape (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .code  (ctrl_q),
        .p4_bit(p4_bit),
        .p5_bit(p5_bit),
        .p9_bit(p9_bit),
        .p4_adv(p4_adv),
        .wave  (wave)
    );

    assign sample = wave ? vol_q : '0;

    assert_sample_is_volume_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sample != '0) |-> (sample == vol_q));
    assert_addr3_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3) |=> ($stable(freq_q) && $stable(ctrl_q) && $stable(vol_q)));
endmodule

// File: tb/tb_poly_tone_channel.sv
`timescale 1ns/1ps
module tb_poly_tone_channel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [4:0] wr_data = 5'd0;
    logic [3:0] sample;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int tick_gap = 1;
    int tphase = 0;
    bit cmp_on = 1'b0;
    string tag = "R11";

    // behavioural model state
    int m_freq, m_ctrl, m_vol, m_cnt, m_lim, m_ph, p4, p5, p9;
    int m_d, m_fb;
    bit m_st, m_p5b, m_phgo, m_phwrap, m_p4go;

    always #10 clk = ~clk;

    poly_tone_channel dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .sample(sample)
    );

    function automatic int div_of(int c);
        case (c)
            2: return 15;
            4, 5, 7: return 2;
            6, 10: return 31;
            12, 13, 15: return 6;
            14: return 93;
            default: return 0;
        endcase
    endfunction

    function automatic int expect_sample();
        bit w;
        case (m_ctrl)
            0, 11: w = 1'b1;
            1, 2, 3: w = p4[0];
            8: w = p9[0];
            9: w = p5[0];
            default: w = (m_ph < div_of(m_ctrl) / 2);
        endcase
        return w ? m_vol : 0;
    endfunction

    function automatic string tag_of(int c);
        case (c)
            0, 11: return "R3";
            1, 8, 9: return "R4";
            2: return "R5";
            3: return "R6";
            7, 15: return "R8";
            default: return "R7";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_freq = 0; m_ctrl = 0; m_vol = 0; m_cnt = 0; m_lim = 0; m_ph = 0;
            p4 = 15; p5 = 31; p9 = 511;
        end else begin
            m_st = tick && (m_cnt >= m_lim);
            if (tick) begin
                if (m_cnt >= m_lim) begin
                    m_cnt = 0;
                    m_lim = m_freq;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
            if (m_st) begin
                m_d = div_of(m_ctrl);
                m_p5b = p5[0];
                m_phgo = (m_d != 0) && (((m_ctrl == 7) || (m_ctrl == 15)) ? m_p5b : 1'b1);
                m_phwrap = m_phgo && (m_ph >= m_d - 1);
                m_p4go = (m_ctrl == 1) || (m_ctrl == 2 && m_phwrap) || (m_ctrl == 3 && m_p5b);
                if (m_phgo) m_ph = m_phwrap ? 0 : m_ph + 1;
                if (m_p4go) begin
                    m_fb = (p4 ^ (p4 >> 1)) & 1;
                    p4 = (m_fb << 3) | (p4 >> 1);
                end
                m_fb = (p5 ^ (p5 >> 2)) & 1;
                p5 = (m_fb << 4) | (p5 >> 1);
                m_fb = (p9 ^ (p9 >> 4)) & 1;
                p9 = (m_fb << 8) | (p9 >> 1);
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_freq = int'(wr_data);
                    2'd1: m_ctrl = int'(wr_data) & 15;
                    2'd2: m_vol = int'(wr_data) & 15;
                    default: ;
                endcase
            end
        end
    end

    // tick pattern
    always @(negedge clk) begin
        if (tick_gap <= 1) begin
            tick = 1'b1;
        end else begin
            tphase = (tphase + 1) % tick_gap;
            tick = (tphase == 0);
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            checks++;
            if (int'(sample) != expect_sample()) begin
                fails++;
                $display("FAIL %s code=%0d actual=%0d expected=%0d", tag, m_ctrl, sample, expect_sample());
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = 2'(a);
        wr_data = 5'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sample == 4'd0, "R11", int'(sample), 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        tag = "R11";
        run(5);
        chk(sample == 4'd0, "R11", int'(sample), 0);

        tag = "R3";
        wr(2, 9);
        chk(sample == 4'd9, "R3", int'(sample), 9);
        run(20);

        tag = "R10";
        wr(3, 31);
        chk(sample == 4'd9, "R10", int'(sample), 9);
        wr(2, 5'h17);
        chk(sample == 4'd7, "R10", int'(sample), 7);
        wr(1, 5'h11);
        run(50);

        for (int c = 0; c < 16; c++) begin
            tag = tag_of(c);
            tick_gap = (c % 3) + 1;
            wr(0, c % 4);
            wr(1, c);
            wr(2, 15 - (c % 5));
            run(700);
            wr(0, (c * 7) % 32);
            run(500);
        end

        tag = "R1";
        wr(1, 4); wr(0, 5); tick_gap = 3;
        run(400);
        wr(0, 31); tick_gap = 1;
        run(300);

        tag = "R2";
        wr(0, 20);
        run(67);
        wr(0, 1);
        run(200);
        wr(1, 14); wr(0, 0);
        run(300);
        wr(1, 4);
        run(40);

        tag = "R9";
        wr(2, 0); wr(1, 9);
        run(200);
        chk(sample == 4'd0, "R9", int'(sample), 0);
        wr(2, 15); wr(1, 1);
        run(200);

        cmp_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule